// File: doc/BRIEF.md
# Configurable Command/Address Register Bank

This block registers the command and address lines of a memory module on the rising clock edge. It has two widths. In the wide mode there are 25 lanes, and each lane has one output. In the split mode only the lower 14 lanes are active, and every active lane drives two identical registered outputs: an A copy and a B copy. These let one input reach two loads.

Three lanes are reserved for control signals:

- **Clock-enable lane** and **termination lane**: always refreshed.
- **Chip-select lane**: carries a registered copy of the chip-select input. Also always refreshed.

The ordinary data lanes are different. They are frozen whenever the chip-select input and the auxiliary chip-select input are both high. An asynchronous active-low reset clears every register at once and overrides the freeze. Two static strap inputs set the behaviour. One picks the width mode. The other, in split mode only, moves the clock-enable and termination lanes to an alternate placement.

Top module: `cmd_addr_regbuf`

## Requirements
- R1: With the freeze condition inactive, each data lane's output equals its `d_in` bit sampled at the previous rising edge (one cycle of latency).
- R2: When `cs_n_in` and `cs_aux_n_in` are both 1 at a rising edge, every data lane output keeps its previous value through that edge.
- R3: The clock-enable lane output takes `cke_in` and the termination lane output takes `odt_in` at every rising edge, whether or not the freeze condition is active. The `d_in` bit at those lanes has no effect.
- R4: Driving `arst_n` low clears `qa_out` and `qb_out` to zero at once, without waiting for a clock edge. They stay zero at every edge while `arst_n` is low, even if the freeze condition is active.
- R5: With `mode_split`=1, `qb_out` equals `qa_out[13:0]` after every edge, and `qa_out[24:14]` stays 0.
- R6: With `mode_split`=0, all 25 lanes are active and `qb_out` stays 0.
- R7: The control lanes are placed as follows (bit index = lane − 1):
  - `mode_split`=1 and `ctrl_swap`=1: clock-enable is at bit 13 and termination at bit 10. Bits 0 and 3 are ordinary data lanes.
  - Otherwise: clock-enable is at bit 0 and termination at bit 3.
- R8: Bit 6 carries `cs_n_in`, registered at every edge and never frozen. The `d_in` bit 6 is ignored.
- R9: With `cs_aux_n_in`=0, the data lanes load on every edge whatever the value of `cs_n_in`.
- R10: After `arst_n` rises, all outputs stay 0 until the first rising edge loads new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst_n | input | 1 | Asynchronous clear, active low |
| mode_split | input | 1 | Strap: 0 = 25 lanes, one output each; 1 = 14 lanes with A and B copies |
| ctrl_swap | input | 1 | Strap: in split mode, 1 selects the alternate control-lane placement |
| d_in | input | 25 | Lane data; bits at control lanes are ignored |
| cs_n_in | input | 1 | Chip select, active low; registered onto bit 6 |
| cs_aux_n_in | input | 1 | Auxiliary chip select; freeze when it and `cs_n_in` are both high |
| odt_in | input | 1 | Termination control, never frozen |
| cke_in | input | 1 | Clock-enable control, never frozen |
| qa_out | output | 25 | Registered A outputs |
| qb_out | output | 14 | Registered B copies (split mode only) |

## Verification
Every lane result is due at the first rising edge after the inputs are applied. This includes the B copies, which come from their own register bank in the same cycle. The bench drives inputs on the falling edge. At the next falling edge it compares each lane group against a reference that was updated at the rising edge in between. Each comparison is labelled with the freeze and the pin condition of that edge.

Asynchronous clear is checked one nanosecond after `arst_n` falls in the middle of a cycle, before any edge can intervene. The reset-release checks sample before the first loading edge.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;
  typedef enum logic [2:0] {
    ROLE_OFF  = 3'd0,
    ROLE_DATA = 3'd1,
    ROLE_CKE  = 3'd2,
    ROLE_ODT  = 3'd3,
    ROLE_CS   = 3'd4
  } lane_role_e;
endpackage

// File: rtl/regbuf_lane_map.sv
module regbuf_lane_map
  import regbuf_pkg::*;
#(
  parameter int NLANE   = 25,
  parameter int NSPLIT  = 14,
  parameter int CS_LANE = 6,
  parameter int CKE_STD = 0,
  parameter int ODT_STD = 3,
  parameter int CKE_ALT = 13,
  parameter int ODT_ALT = 10
) (
  input  logic                          mode_split,
  input  logic                          ctrl_swap,
  output lane_role_e [NLANE-1:0]        roles
);
  logic use_alt;
  assign use_alt = mode_split & ctrl_swap;

  always_comb begin
    for (int i = 0; i < NLANE; i++) begin
      if (mode_split && i >= NSPLIT)
        roles[i] = ROLE_OFF;
      else if (i == CS_LANE)
        roles[i] = ROLE_CS;
      else if (i == (use_alt ? CKE_ALT : CKE_STD))
        roles[i] = ROLE_CKE;
      else if (i == (use_alt ? ODT_ALT : ODT_STD))
        roles[i] = ROLE_ODT;
      else
        roles[i] = ROLE_DATA;
    end
  end
endmodule

// File: rtl/regbuf_lane_reg.sv
module regbuf_lane_reg
  import regbuf_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  lane_role_e role,
  input  logic       d,
  input  logic       cs_n,
  input  logic       odt,
  input  logic       cke,
  input  logic       freeze,
  output logic       nxt,
  output logic       q
);
  always_comb begin
    case (role)
      ROLE_CKE:  nxt = cke;
      ROLE_ODT:  nxt = odt;
      ROLE_CS:   nxt = cs_n;
      ROLE_DATA: nxt = freeze ? q : d;
      default:   nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= 1'b0;
    else         q <= nxt;
  end

  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!arst_n)
    (role == ROLE_DATA && !freeze) |=> (q == $past(d)));            // R1
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    (role == ROLE_DATA && freeze) |=> $stable(q));                  // R2
  AST_CKE_FOLLOW: assert property (@(posedge clk) disable iff (!arst_n)
    (role == ROLE_CKE) |=> (q == $past(cke)));                      // R3
  AST_ODT_FOLLOW: assert property (@(posedge clk) disable iff (!arst_n)
    (role == ROLE_ODT) |=> (q == $past(odt)));                      // R3
  AST_CS_FOLLOW: assert property (@(posedge clk) disable iff (!arst_n)
    (role == ROLE_CS) |=> (q == $past(cs_n)));                      // R8
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!arst_n)
    (role == ROLE_OFF) |=> !q);                                     // R5
endmodule

// File: rtl/regbuf_fanout.sv
module regbuf_fanout #(
  parameter int NSPLIT = 14
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              mode_split,
  input  logic [NSPLIT-1:0] nxt_low,
  output logic [NSPLIT-1:0] qb
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)         qb <= '0;
    else if (mode_split) qb <= nxt_low;
    else                 qb <= '0;
  end
endmodule

// File: rtl/cmd_addr_regbuf.sv
module cmd_addr_regbuf
  import regbuf_pkg::*;
#(
  parameter int NLANE   = 25,
  parameter int NSPLIT  = 14,
  parameter int CS_LANE = 6,
  parameter int CKE_STD = 0,
  parameter int ODT_STD = 3,
  parameter int CKE_ALT = 13,
  parameter int ODT_ALT = 10
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              mode_split,
  input  logic              ctrl_swap,
  input  logic [NLANE-1:0]  d_in,
  input  logic              cs_n_in,
  input  logic              cs_aux_n_in,
  input  logic              odt_in,
  input  logic              cke_in,
  output logic [NLANE-1:0]  qa_out,
  output logic [NSPLIT-1:0] qb_out
);
  lane_role_e [NLANE-1:0] roles;
  logic [NLANE-1:0]       nxt;
  logic                   freeze;

  assign freeze = cs_n_in & cs_aux_n_in;

  regbuf_lane_map #(
    .NLANE(NLANE), .NSPLIT(NSPLIT), .CS_LANE(CS_LANE),
    .CKE_STD(CKE_STD), .ODT_STD(ODT_STD),
    .CKE_ALT(CKE_ALT), .ODT_ALT(ODT_ALT)
  ) u_map (
    .mode_split (mode_split),
    .ctrl_swap  (ctrl_swap),
    .roles      (roles)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    regbuf_lane_reg u_lane (
      .clk    (clk),
      .arst_n (arst_n),
      .role   (roles[g]),
      .d      (d_in[g]),
      .cs_n   (cs_n_in),
      .odt    (odt_in),
      .cke    (cke_in),
      .freeze (freeze),
      .nxt    (nxt[g]),
      .q      (qa_out[g])
    );
  end

  regbuf_fanout #(.NSPLIT(NSPLIT)) u_fan (
    .clk        (clk),
    .arst_n     (arst_n),
    .mode_split (mode_split),
    .nxt_low    (nxt[NSPLIT-1:0]),
    .qb         (qb_out)
  );

  AST_B_MIRROR: assert property (@(posedge clk) disable iff (!arst_n)
    mode_split |-> (qb_out == qa_out[NSPLIT-1:0]));                 // R5
  AST_B_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
    !mode_split |-> (qb_out == '0));                                // R6
  AST_UPPER_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
    mode_split |=> (qa_out[NLANE-1:NSPLIT] == '0));                 // R5
endmodule

// File: tb/sim_cmd_addr_regbuf.sv
module sim_cmd_addr_regbuf;
  localparam int CLK_P = 10;
  localparam int NL = 25;
  localparam int NS = 14;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic mode_split = 1'b0, ctrl_swap = 1'b0;
  logic [NL-1:0] d_in = '0;
  logic cs_n_in = 1'b0, cs_aux_n_in = 1'b0, odt_in = 1'b0, cke_in = 1'b0;
  logic [NL-1:0] qa_out;
  logic [NS-1:0] qb_out;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  cmd_addr_regbuf u0 (
    .clk(clk), .arst_n(arst_n), .mode_split(mode_split), .ctrl_swap(ctrl_swap),
    .d_in(d_in), .cs_n_in(cs_n_in), .cs_aux_n_in(cs_aux_n_in),
    .odt_in(odt_in), .cke_in(cke_in), .qa_out(qa_out), .qb_out(qb_out)
  );

  // role codes: 0 unused, 1 data, 2 clock-enable, 3 termination, 4 chip select
  function automatic int lane_kind(int i, logic split, logic swap);
    if (split && i >= NS) return 0;
    if (i == 6) return 4;
    if (split && swap) begin
      if (i == 13) return 2;
      if (i == 10) return 3;
    end else begin
      if (i == 0) return 2;
      if (i == 3) return 3;
    end
    return 1;
  endfunction

  logic [NL-1:0] ma;
  logic [NS-1:0] mb;
  logic [NL-1:0] nx;
  logic last_frz, last_aux;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ma <= '0; mb <= '0; last_frz <= 1'b0; last_aux <= 1'b0;
    end else begin
      for (int i = 0; i < NL; i++) begin
        case (lane_kind(i, mode_split, ctrl_swap))
          1: nx[i] = (cs_n_in && cs_aux_n_in) ? ma[i] : d_in[i];
          2: nx[i] = cke_in;
          3: nx[i] = odt_in;
          4: nx[i] = cs_n_in;
          default: nx[i] = 1'b0;
        endcase
      end
      ma <= nx;
      mb <= mode_split ? nx[NS-1:0] : '0;
      last_frz <= cs_n_in && cs_aux_n_in;
      last_aux <= cs_aux_n_in;
    end
  end

  task automatic check(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [NL-1:0] mdat = '0, mctl = '0, mcs = '0, moff = '0;
    for (int i = 0; i < NL; i++) begin
      case (lane_kind(i, mode_split, ctrl_swap))
        0: moff[i] = 1'b1;
        1: mdat[i] = 1'b1;
        4: mcs[i]  = 1'b1;
        default: mctl[i] = 1'b1;
      endcase
    end
    if (last_frz)       check("R2 data lanes frozen", qa_out & mdat, ma & mdat);
    else if (!last_aux) check("R9 data lanes ungated", qa_out & mdat, ma & mdat);
    else                check("R1 data lanes load", qa_out & mdat, ma & mdat);
    if (mode_split && ctrl_swap) check("R7 alt control lanes", qa_out & mctl, ma & mctl);
    else                         check("R3 control lanes", qa_out & mctl, ma & mctl);
    check("R8 chip-select lane", qa_out & mcs, ma & mcs);
    if (mode_split) begin
      check("R5 unused upper lanes low", qa_out & moff, '0);
      check("R5 B copies", {{(NL-NS){1'b0}}, qb_out}, {{(NL-NS){1'b0}}, mb});
    end else begin
      check("R6 B copies low", {{(NL-NS){1'b0}}, qb_out}, '0);
    end
  endtask

  task automatic rand_drive(int frz_bias);
    d_in        = NL'({$urandom, $urandom});
    cs_n_in     = ($urandom % 4) < frz_bias;
    cs_aux_n_in = $urandom % 2;
    odt_in      = $urandom % 2;
    cke_in      = $urandom % 2;
  endtask

  task automatic run_cfg(logic split, logic swap);
    @(negedge clk);
    arst_n = 1'b0;
    mode_split = split; ctrl_swap = swap;
    d_in = '1; cs_n_in = 1'b1; cs_aux_n_in = 1'b1; odt_in = 1'b1; cke_in = 1'b1;
    @(negedge clk);
    check("R4 reset held A", qa_out, '0);
    check("R4 reset held B", {{(NL-NS){1'b0}}, qb_out}, '0);
    d_in = '0; cs_n_in = 1'b0; cs_aux_n_in = 1'b0; odt_in = 1'b0; cke_in = 1'b0;
    arst_n = 1'b1;
    #1;
    check("R10 low after release A", qa_out, '0);
    check("R10 low after release B", {{(NL-NS){1'b0}}, qb_out}, '0);
    rand_drive(2);
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      compare_all();
      rand_drive(3);
    end
    // directed: freeze with all inputs changing
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      compare_all();
      d_in = ~d_in; cs_n_in = 1'b1; cs_aux_n_in = 1'b1;
      odt_in = ~odt_in; cke_in = ~cke_in;
    end
    // directed: auxiliary low with chip select high
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      compare_all();
      d_in = ~d_in; cs_n_in = 1'b1; cs_aux_n_in = 1'b0;
    end
    @(negedge clk);
    compare_all();
    // mid-cycle asynchronous clear with freeze inputs active
    d_in = '1; cs_n_in = 1'b1; cs_aux_n_in = 1'b1; odt_in = 1'b1; cke_in = 1'b1;
    @(posedge clk);
    #(CLK_P/4);
    arst_n = 1'b0;
    #1;
    check("R4 async clear A", qa_out, '0);
    check("R4 async clear B", {{(NL-NS){1'b0}}, qb_out}, '0);
    @(negedge clk);
    @(negedge clk);
    check("R4 clear beats freeze", qa_out, '0);
    arst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h1b5e_77a1));
    run_cfg(1'b0, 1'b0);
    run_cfg(1'b0, 1'b1);
    run_cfg(1'b1, 1'b0);
    run_cfg(1'b1, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule